// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. An operation code and two byte operands go in: the second operand may come from a register or from an immediate field, and the block does not care which. A byte result comes out combinationally in the same cycle. Alongside the datapath sits an 8-bit status register that records carry, zero, negative, overflow, signed, half-carry, a user bit and an interrupt-enable bit. The stored carry and zero flags feed back into the carry-using operations.

When `op_valid` is high, the status register takes its new value at the next rising clock edge. Each operation writes only its own subset of flags. Every other bit keeps its value, so code can rely on carry surviving an increment, or on the user bit surviving arithmetic. The block accepts one operation every cycle and never stalls, so there is no back-pressure: `op_valid` is a commit strobe only. The result port is meaningful in the cycle the operation is presented.

Top module: `alu8_flags`

## Requirements
- R1: Status bit positions, from bit 7 down to bit 0, are I, T, H, S, V, N, Z, C. Reset clears all eight bits. A cycle without `op_valid` leaves the register unchanged.
- R2: ADD and ADC give a+b (+C for ADC). They write C (carry out of bit 7), Z, N, V (signed overflow) and H (carry out of bit 3).
- R3: SUB and SBC give a−b (−C for SBC), and NEG gives 0−a. They write C (borrow), Z, N, V and H (borrow out of bit 4 into bit 3).
- R4: SBC never sets Z. Z becomes 1 only if the result is zero and Z was already 1.
- R5: AND, OR and XOR write Z and N and clear V. C, H, T and I are unchanged.
- R6: INC and DEC write only Z, N, V and S. V is set on the step from 0x7F to 0x80 (INC) and from 0x80 to 0x7F (DEC). C is never touched.
- R7: COM gives 0xFF−a. It sets C to 1, clears V, and writes Z and N.
- R8: LSL moves bit 7 into C and puts 0 in bit 0. LSR moves bit 0 into C and puts 0 in bit 7. ASR moves bit 0 into C and keeps bit 7. All three write Z and N and set V = N xor C.
- R9: ROL puts the old C into bit 0 and bit 7 into C. ROR puts the old C into bit 7 and bit 0 into C. Both write Z and N and set V = N xor C.
- R10: SWAP exchanges the two nibbles and SER returns 0xFF. Neither changes any flag.
- R11: FSET and FCLR force status bit `flag_idx` (0..7) to 1 or 0 and leave the other seven bits alone.
- R12: Whenever an operation writes N or V, S becomes the new N xor the new V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit the flag update of this cycle's operation |
| op_code | input | 5 | Operation select (values of `alu8_pkg::op_e`) |
| opd_a | input | 8 | First operand (destination register value) |
| opd_b | input | 8 | Second operand (register or immediate) |
| flag_idx | input | 3 | Status bit index for FSET / FCLR |
| result | output | 8 | Combinational result of the operation |
| sreg | output | 8 | Status register {I,T,H,S,V,N,Z,C} |

## Verification
A wrong flag mask shows up at `sreg` one edge after the operation. A bit that should have been kept is overwritten, or a bit that should have been written keeps its old value. Both cases are visible as soon as the register is sampled. A wrong carry or zero feedback hides until a later ADC, SBC or rotate uses it. At that point it appears as a result off by one, or a Z that should have stayed clear, one operation later. Because of this, the directed tests preload the flags before each carry-using operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int SR_W   = 8;
  localparam int IDX_W  = $clog2(SR_W);
  localparam int OP_W   = 5;
  localparam int SR_C = 0, SR_Z = 1, SR_N = 2, SR_V = 3;
  localparam int SR_S = 4, SR_H = 5, SR_T = 6, SR_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
    OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC,
    OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR,
    OP_SWAP, OP_SER, OP_FSET, OP_FCLR
  } op_e;

  typedef struct packed {
    logic [SR_W-1:0] mask;
    logic [SR_W-1:0] val;
  } fupd_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              zin,
  output logic [DATA_W-1:0] res,
  output fupd_t             upd
);
  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic              sub, cy, v, n, z;
  logic [DATA_W-1:0] x, y;
  logic [DATA_W:0]   full;
  logic [NIB:0]      half;

  always_comb begin
    sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG);
    x   = (op == OP_NEG) ? '0 : a;
    y   = (op == OP_NEG) ? a : b;
    cy  = ((op == OP_ADC) || (op == OP_SBC)) ? cin : 1'b0;
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cy};
      half = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - {{NIB{1'b0}}, cy};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cy};
      half = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, cy};
    end
    res = full[MSB:0];
    n   = res[MSB];
    v   = sub ? ((x[MSB] != y[MSB]) && (res[MSB] != x[MSB]))
              : ((x[MSB] == y[MSB]) && (res[MSB] != x[MSB]));
    z   = (res == '0) && ((op == OP_SBC) ? zin : 1'b1);
    upd.mask = '0;
    upd.val  = '0;
    upd.mask[SR_C] = 1'b1; upd.val[SR_C] = full[DATA_W];
    upd.mask[SR_Z] = 1'b1; upd.val[SR_Z] = z;
    upd.mask[SR_N] = 1'b1; upd.val[SR_N] = n;
    upd.mask[SR_V] = 1'b1; upd.val[SR_V] = v;
    upd.mask[SR_S] = 1'b1; upd.val[SR_S] = n ^ v;
    upd.mask[SR_H] = 1'b1; upd.val[SR_H] = half[NIB];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output fupd_t             upd
);
  localparam int MSB = DATA_W - 1;
  localparam int NIB = DATA_W / 2;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic c, c_wr, v, shift_v, nzv_wr, n, vf;

  always_comb begin
    res     = a;
    c       = 1'b0;
    c_wr    = 1'b0;
    v       = 1'b0;
    shift_v = 1'b0;
    nzv_wr  = 1'b1;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_COM: begin res = ~a; c = 1'b1; c_wr = 1'b1; end
      OP_INC: begin res = a + 1'b1; v = (res == MIN_NEG); end
      OP_DEC: begin res = a - 1'b1; v = (res == MAX_POS); end
      OP_LSL: begin res = {a[MSB-1:0], 1'b0}; c = a[MSB]; c_wr = 1'b1; shift_v = 1'b1; end
      OP_LSR: begin res = {1'b0, a[MSB:1]};   c = a[0];   c_wr = 1'b1; shift_v = 1'b1; end
      OP_ASR: begin res = {a[MSB], a[MSB:1]}; c = a[0];   c_wr = 1'b1; shift_v = 1'b1; end
      OP_ROL: begin res = {a[MSB-1:0], cin};  c = a[MSB]; c_wr = 1'b1; shift_v = 1'b1; end
      OP_ROR: begin res = {cin, a[MSB:1]};    c = a[0];   c_wr = 1'b1; shift_v = 1'b1; end
      OP_SWAP: begin res = {a[NIB-1:0], a[MSB:NIB]}; nzv_wr = 1'b0; end
      OP_SER:  begin res = '1; nzv_wr = 1'b0; end
      default: nzv_wr = 1'b0;
    endcase
    n  = res[MSB];
    vf = shift_v ? (n ^ c) : v;
    upd.mask = '0;
    upd.val  = '0;
    upd.mask[SR_C] = c_wr;   upd.val[SR_C] = c;
    upd.mask[SR_Z] = nzv_wr; upd.val[SR_Z] = (res == '0);
    upd.mask[SR_N] = nzv_wr; upd.val[SR_N] = n;
    upd.mask[SR_V] = nzv_wr; upd.val[SR_V] = vf;
    upd.mask[SR_S] = nzv_wr; upd.val[SR_S] = n ^ vf;
  end
endmodule

// File: rtl/alu8_flagop.sv
module alu8_flagop
  import alu8_pkg::*;
(
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  output fupd_t            upd
);
  logic [SR_W-1:0] onehot;

  always_comb begin
    onehot   = '0;
    onehot[idx] = 1'b1;
    upd.mask = ((op == OP_FSET) || (op == OP_FCLR)) ? onehot : '0;
    upd.val  = (op == OP_FSET) ? onehot : '0;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opd_a,
  input  logic [DATA_W-1:0] opd_b,
  input  logic [IDX_W-1:0]  flag_idx,
  output logic [DATA_W-1:0] result,
  output logic [SR_W-1:0]   sreg
);
  op_e               op;
  logic [DATA_W-1:0] as_res, lg_res;
  fupd_t             as_upd, lg_upd, fl_upd, sel_upd;
  logic [SR_W-1:0]   sreg_d;
  logic              grp_as, grp_lg;

  assign op = op_e'(op_code);

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op), .a(opd_a), .b(opd_b), .cin(sreg[SR_C]), .zin(sreg[SR_Z]),
    .res(as_res), .upd(as_upd)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .a(opd_a), .b(opd_b), .cin(sreg[SR_C]),
    .res(lg_res), .upd(lg_upd)
  );

  alu8_flagop u_flagop (
    .op(op), .idx(flag_idx), .upd(fl_upd)
  );

  always_comb begin
    grp_as = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
             (op == OP_SBC) || (op == OP_NEG);
    grp_lg = !grp_as && (op != OP_FSET) && (op != OP_FCLR);
    if (grp_as) begin
      result  = as_res;
      sel_upd = as_upd;
    end else if (grp_lg) begin
      result  = lg_res;
      sel_upd = lg_upd;
    end else begin
      result  = opd_a;
      sel_upd = fl_upd;
    end
    sreg_d = (sreg & ~sel_upd.mask) | (sel_upd.val & sel_upd.mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (op_valid) sreg <= sreg_d;
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_code,
  input logic [7:0]       opd_a,
  input logic [IDX_W-1:0] flag_idx,
  input logic [SR_W-1:0]  sreg
);
  logic writes_nv, keeps_c, clears_v;

  always_comb begin
    writes_nv = op_valid && (op_code != OP_SWAP) && (op_code != OP_SER) &&
                (op_code != OP_FSET) && (op_code != OP_FCLR);
    keeps_c   = op_valid && ((op_code == OP_AND) || (op_code == OP_OR) ||
                (op_code == OP_XOR) || (op_code == OP_INC) || (op_code == OP_DEC));
    clears_v  = op_valid && ((op_code == OP_AND) || (op_code == OP_OR) ||
                (op_code == OP_XOR));
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(sreg)); // R1
  AST_SBC_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SBC && !sreg[SR_Z]) |=> !sreg[SR_Z]); // R4
  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clears_v |=> !sreg[SR_V]); // R5
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    keeps_c |=> (sreg[SR_C] == $past(sreg[SR_C]))); // R6
  AST_COM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_COM) |=> (sreg[SR_C] && !sreg[SR_V])); // R7
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ROL) |=> (sreg[SR_C] == $past(opd_a[7]))); // R9
  AST_NOFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_SWAP || op_code == OP_SER)) |=> $stable(sreg)); // R10
  AST_FSET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_FSET) |=> sreg[$past(flag_idx)]); // R11
  AST_FCLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_FCLR) |=> !sreg[$past(flag_idx)]); // R11
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    writes_nv |=> (sreg[SR_S] == (sreg[SR_N] ^ sreg[SR_V]))); // R12
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opd_a(opd_a), .flag_idx(flag_idx), .sreg(sreg)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opd_a = '0, opd_b = '0;
  logic [2:0] flag_idx = '0;
  logic [7:0] result, sreg;
  logic [7:0] got_res, got_sr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opd_a(opd_a), .opd_b(opd_b), .flag_idx(flag_idx),
    .result(result), .sreg(sreg)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic exec(input op_e op, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] idx);
    @(negedge clk);
    op_code = op; opd_a = a; opd_b = b; flag_idx = idx; op_valid = 1'b1;
    #1 got_res = result;
    @(negedge clk);
    op_valid = 1'b0;
    got_sr = sreg;
  endtask

  task automatic set_flags(input logic [7:0] v);
    for (int i = 0; i < 8; i++) exec(v[i] ? OP_FSET : OP_FCLR, 8'h00, 8'h00, 3'(i));
  endtask

  task automatic t_reset_idle;
    chk("R1 reset sreg", sreg, 8'h00);
    set_flags(8'h5A);
    chk("R1 preload", sreg, 8'h5A);
    @(negedge clk);
    op_code = OP_ADD; opd_a = 8'h80; opd_b = 8'h80; op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle hold", sreg, 8'h5A);
  endtask

  task automatic t_add;
    set_flags(8'h00);
    exec(OP_ADD, 8'h0F, 8'h01, 0);
    chk("R2 add res", got_res, 8'h10); chk("R2 add half", got_sr, 8'h20);
    set_flags(8'h00);
    exec(OP_ADD, 8'h80, 8'h80, 0);
    chk("R2 add res wrap", got_res, 8'h00); chk("R2 add C/V/Z", got_sr, 8'h1B);
    set_flags(8'h01);
    exec(OP_ADC, 8'h7F, 8'h00, 0);
    chk("R2 adc res", got_res, 8'h80); chk("R2 adc flags", got_sr, 8'h2C);
  endtask

  task automatic t_sub;
    set_flags(8'h00);
    exec(OP_SUB, 8'h10, 8'h01, 0);
    chk("R3 sub res", got_res, 8'h0F); chk("R3 sub half borrow", got_sr, 8'h20);
    set_flags(8'h00);
    exec(OP_SUB, 8'h01, 8'h02, 0);
    chk("R3 sub res neg", got_res, 8'hFF); chk("R3 sub borrow", got_sr, 8'h35);
    set_flags(8'h00);
    exec(OP_SUB, 8'h80, 8'h01, 0);
    chk("R3 sub res ovf", got_res, 8'h7F); chk("R3 sub ovf", got_sr, 8'h38);
    set_flags(8'h00);
    exec(OP_NEG, 8'h01, 8'h00, 0);
    chk("R3 neg res", got_res, 8'hFF); chk("R3 neg flags", got_sr, 8'h35);
    set_flags(8'h00);
    exec(OP_NEG, 8'h80, 8'h00, 0);
    chk("R3 neg min res", got_res, 8'h80); chk("R3 neg min flags", got_sr, 8'h0D);
    set_flags(8'h00);
    exec(OP_NEG, 8'h00, 8'h00, 0);
    chk("R3 neg zero flags", got_sr, 8'h02);
  endtask

  task automatic t_sbc_zero;
    set_flags(8'h02);
    exec(OP_SBC, 8'h05, 8'h05, 0);
    chk("R4 sbc z kept", got_sr, 8'h02);
    set_flags(8'h00);
    exec(OP_SBC, 8'h05, 8'h05, 0);
    chk("R4 sbc res", got_res, 8'h00); chk("R4 sbc z not set", got_sr, 8'h00);
    set_flags(8'h03);
    exec(OP_SBC, 8'h05, 8'h04, 0);
    chk("R4 sbc carry res", got_res, 8'h00); chk("R4 sbc carry flags", got_sr, 8'h02);
  endtask

  task automatic t_logic;
    set_flags(8'hE9);
    exec(OP_AND, 8'hF0, 8'h8F, 0);
    chk("R5 and res", got_res, 8'h80); chk("R5 and flags", got_sr, 8'hF5);
    exec(OP_OR, 8'h00, 8'h00, 0);
    chk("R5 or flags", got_sr, 8'hE3);
    exec(OP_XOR, 8'h0F, 8'hF0, 0);
    chk("R5 xor res", got_res, 8'hFF); chk("R5 xor flags", got_sr, 8'hF5);
  endtask

  task automatic t_incdec;
    set_flags(8'h01);
    exec(OP_INC, 8'h7F, 8'h00, 0);
    chk("R6 inc res", got_res, 8'h80); chk("R6 inc ovf", got_sr, 8'h0D);
    exec(OP_INC, 8'hFF, 8'h00, 0);
    chk("R6 inc wrap", got_sr, 8'h03);
    set_flags(8'h00);
    exec(OP_DEC, 8'h80, 8'h00, 0);
    chk("R6 dec res", got_res, 8'h7F); chk("R6 dec ovf", got_sr, 8'h18);
    exec(OP_DEC, 8'h00, 8'h00, 0);
    chk("R6 dec wrap C kept", got_sr, 8'h14);
  endtask

  task automatic t_com;
    set_flags(8'h08);
    exec(OP_COM, 8'h0F, 8'h00, 0);
    chk("R7 com res", got_res, 8'hF0); chk("R7 com flags", got_sr, 8'h15);
    exec(OP_COM, 8'hFF, 8'h00, 0);
    chk("R7 com zero", got_sr, 8'h03);
  endtask

  task automatic t_shift;
    set_flags(8'h00);
    exec(OP_LSL, 8'h81, 8'h00, 0);
    chk("R8 lsl res", got_res, 8'h02); chk("R8 lsl flags", got_sr, 8'h19);
    set_flags(8'h00);
    exec(OP_LSR, 8'h01, 8'h00, 0);
    chk("R8 lsr res", got_res, 8'h00); chk("R8 lsr flags", got_sr, 8'h1B);
    set_flags(8'h00);
    exec(OP_ASR, 8'h81, 8'h00, 0);
    chk("R8 asr res", got_res, 8'hC0); chk("R8 asr flags", got_sr, 8'h15);
  endtask

  task automatic t_rotate;
    set_flags(8'h01);
    exec(OP_ROL, 8'h80, 8'h00, 0);
    chk("R9 rol res", got_res, 8'h01); chk("R9 rol flags", got_sr, 8'h19);
    set_flags(8'h00);
    exec(OP_ROL, 8'h40, 8'h00, 0);
    chk("R9 rol c0 res", got_res, 8'h80); chk("R9 rol c0 flags", got_sr, 8'h0C);
    set_flags(8'h01);
    exec(OP_ROR, 8'h02, 8'h00, 0);
    chk("R9 ror res", got_res, 8'h81); chk("R9 ror flags", got_sr, 8'h0C);
    set_flags(8'h00);
    exec(OP_ROR, 8'h01, 8'h00, 0);
    chk("R9 ror c0 res", got_res, 8'h00); chk("R9 ror c0 flags", got_sr, 8'h1B);
  endtask

  task automatic t_noflag;
    set_flags(8'hA5);
    exec(OP_SWAP, 8'h3C, 8'h00, 0);
    chk("R10 swap res", got_res, 8'hC3); chk("R10 swap flags", got_sr, 8'hA5);
    exec(OP_SER, 8'h12, 8'h00, 0);
    chk("R10 ser res", got_res, 8'hFF); chk("R10 ser flags", got_sr, 8'hA5);
  endtask

  task automatic t_flagop;
    set_flags(8'h00);
    exec(OP_FSET, 8'h00, 8'h00, 3'd5);
    chk("R11 set H", got_sr, 8'h20);
    exec(OP_FSET, 8'h00, 8'h00, 3'd7);
    chk("R11 set I", got_sr, 8'hA0);
    exec(OP_FCLR, 8'h00, 8'h00, 3'd5);
    chk("R11 clear H", got_sr, 8'h80);
  endtask

  task automatic t_sign;
    set_flags(8'h00);
    exec(OP_ADD, 8'h40, 8'h40, 0);
    chk("R12 S=N^V ovf", got_sr, 8'h0C);
    set_flags(8'h10);
    exec(OP_AND, 8'h01, 8'h01, 0);
    chk("R12 S cleared", got_sr, 8'h00);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_add();
    t_sub();
    t_sbc_zero();
    t_logic();
    t_incdec();
    t_com();
    t_shift();
    t_rotate();
    t_noflag();
    t_flagop();
    t_sign();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule